// File: doc/BRIEF.md
# Card Data FIFO with Partial-Buffer Flush

This block sits between a host register interface and the byte stream of a memory card. In the write direction the host pushes 1 to 4 bytes per access into a transmit buffer. That buffer is built as two 32-byte halves, and the block streams bytes from it to the card. In the read direction the block pulls bytes from the card into a 32-byte receive ring, and the host drains the ring 1 to 4 bytes per access. Multi-byte host words carry the earliest byte in their most significant lane.

A transfer is armed by a start pulse that gives the direction and a byte count. The count runs down by one for every byte that crosses the card side. The count drives the transmit and receive request flags. When it reaches zero the transfer stops and the block raises data-done, plus programming-done for writes. A partial-buffer flush moves the transmit side to the other half and discards whatever is queued. A clock-stop pulse abandons the transfer.

Top module: `card_data_fifo`

## Requirements
- R1: After reset no transfer is active, both buffers are empty, transmit half 0 is selected, `tx_valid`, `rx_ready`, `tx_req`, `rx_req`, `data_done` and `prog_done` are 0, and a host read returns 0.
- R2: A host write of size N (1..4; larger values act as 4, 0 moves nothing) queues the bytes of `hw_data[8N-1:0]` from the most significant lane down to lane 0.
- R3: The transmit buffer holds at most 32 bytes. Bytes of a host write beyond that limit are dropped.
- R4: While a write transfer is active with bytes remaining and the transmit buffer non-empty, `tx_valid` is 1 and queued bytes leave in queue order. Buffer pointers wrap modulo 32.
- R5: `tx_req` is 1 from the cycle after a write transfer's start while bytes remain. A host write clears it only when no bytes remain.
- R6: While a read transfer is active with bytes remaining and fewer than 32 bytes in the receive ring, `rx_ready` is 1, and each handshake appends `rx_byte` to the ring.
- R7: Each byte taken from the card sets `rx_req`. A host read in a cycle with no byte taken clears it.
- R8: A host read of size N removes up to N bytes. The first byte appears in lane N-1 of `hr_data`, later bytes in lower lanes, and lanes with no byte are 0.
- R9: When the remaining count reaches zero, `xfer_active` falls and `data_done` rises on the same clock edge.
- R10: `prog_done` rises together with `data_done` only for a write transfer.
- R11: A `pbuf_flush` pulse selects the other transmit half and empties the transmit buffer. A host write in the same cycle is dropped, and the discarded bytes are never sent.
- R12: A `clk_stop` pulse makes the transfer inactive on the next edge without raising `data_done`. It wins over a start in the same cycle.
- R13: A start pulse empties both buffers, clears all four flags, and loads the byte count and direction (`xfer_wr` 1 = to the card).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Arm a transfer |
| xfer_wr | input | 1 | Direction at start: 1 writes to the card |
| xfer_len | input | LEN_W | Byte count at start |
| clk_stop | input | 1 | Abandon the transfer |
| pbuf_flush | input | 1 | Switch transmit half, discard queued bytes |
| hw_en | input | 1 | Host write access |
| hw_size | input | 3 | Host write byte count |
| hw_data | input | 32 | Host write word |
| hr_en | input | 1 | Host read access |
| hr_size | input | 3 | Host read byte count |
| hr_data | output | 32 | Host read word (same cycle as `hr_en`) |
| tx_byte | output | 8 | Byte to the card |
| tx_valid | output | 1 | `tx_byte` is valid |
| tx_ready | input | 1 | Card accepts `tx_byte` |
| rx_byte | input | 8 | Byte from the card |
| rx_valid | input | 1 | `rx_byte` is valid |
| rx_ready | output | 1 | Block accepts `rx_byte` |
| tx_req | output | 1 | Transmit request flag |
| rx_req | output | 1 | Receive request flag |
| data_done | output | 1 | Transfer completed |
| prog_done | output | 1 | Write transfer completed |
| xfer_active | output | 1 | Transfer in progress |

## Verification
The hardest states to reach are the two full conditions after the pointers have wrapped.

For the receive ring, the card must be held streaming while the host stays idle until the ring reaches 32 bytes. The stimulus then interleaves 4-byte host reads with card bytes, so that both pointers cross the 32-entry boundary while the ring runs close to full. On every cycle `rx_ready` is compared against a count the bench keeps itself.

For the transmit side, the card is stalled while nine 4-byte host writes overfill the buffer. The buffer is then drained and refilled across the wrap.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
   localparam int unsigned LANES = 4;

   function automatic logic [2:0] clamp_size(input logic [2:0] sz);
      return (sz > 3'd4) ? 3'd4 : sz;
   endfunction

   // byte i (0 = earliest) of an n-byte host word, most significant lane first
   function automatic logic [7:0] lane_pick(input logic [31:0] w,
                                            input logic [2:0]  n,
                                            input int          i);
      int sh;
      sh = 8 * (int'(n) - 1 - i);
      return (sh < 0) ? 8'h00 : 8'(w >> sh);
   endfunction
endpackage

// File: rtl/cdf_txbuf.sv
module cdf_txbuf #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned CW = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          flip,
   input  logic          wr_en,
   input  logic [2:0]    wr_size,
   input  logic [31:0]   wr_data,
   input  logic          pop,
   output logic [CW-1:0] count,
   output logic [7:0]    head
);
   import cdf_pkg::*;

   logic [7:0]    mem [2*DEPTH];
   logic          half_q;
   logic [PW-1:0] rd_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] room, wsz, npush;
   logic [2:0]    wsz3;

   assign wsz3  = clamp_size(wr_size);
   assign wsz   = CW'(wsz3);
   assign room  = CW'(DEPTH) - cnt_q;
   assign npush = (wr_en && !clear && !flip) ? ((wsz > room) ? room : wsz) : '0;
   assign count = cnt_q;
   assign head  = mem[{half_q, rd_q}];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (CW'(i) < npush)
            mem[{half_q, PW'(rd_q + cnt_q[PW-1:0] + PW'(i))}] <= lane_pick(wr_data, wsz3, i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         rd_q   <= '0;
         cnt_q  <= '0;
      end else begin
         if (pop) rd_q <= rd_q + 1'b1;
         if (flip) half_q <= ~half_q;
         if (clear || flip) cnt_q <= '0;
         else               cnt_q <= cnt_q + npush - CW'(pop);
      end
   end
endmodule

// File: rtl/cdf_rxring.sv
module cdf_rxring #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned CW = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic [7:0]    push_data,
   input  logic          rd_en,
   input  logic [2:0]    rd_size,
   output logic [31:0]   rd_data,
   output logic [CW-1:0] count
);
   import cdf_pkg::*;

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] rd_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] rsz, npop;
   logic [2:0]    rsz3;

   assign rsz3  = clamp_size(rd_size);
   assign rsz   = CW'(rsz3);
   assign npop  = (rd_en && !clear) ? ((rsz > cnt_q) ? cnt_q : rsz) : '0;
   assign count = cnt_q;

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < LANES; i++) begin
         if (CW'(i) < npop)
            rd_data = rd_data |
                      (32'(mem[PW'(rd_q + PW'(i))]) << (8 * (int'(rsz3) - 1 - i)));
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[PW'(rd_q + cnt_q[PW-1:0])] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         rd_q <= rd_q + PW'(npop);
         if (clear) cnt_q <= '0;
         else       cnt_q <= cnt_q + CW'(push) - npop;
      end
   end
endmodule

// File: rtl/cdf_ctrl.sv
module cdf_ctrl #(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_wr,
   input  logic [LEN_W-1:0] start_len,
   input  logic             stop,
   input  logic             moved,
   input  logic             rx_took,
   input  logic             host_wr,
   input  logic             host_rd,
   output logic             active,
   output logic             dir_wr,
   output logic             rem_nz,
   output logic             tx_req,
   output logic             rx_req,
   output logic             data_done,
   output logic             prog_done
);
   logic [LEN_W-1:0] rem_q, rem_after;

   assign rem_after = rem_q - LEN_W'(moved);
   assign rem_nz    = (rem_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q     <= '0;
         active    <= 1'b0;
         dir_wr    <= 1'b0;
         tx_req    <= 1'b0;
         rx_req    <= 1'b0;
         data_done <= 1'b0;
         prog_done <= 1'b0;
      end else if (start) begin
         rem_q     <= start_len;
         dir_wr    <= start_wr;
         active    <= !stop;
         tx_req    <= 1'b0;
         rx_req    <= 1'b0;
         data_done <= 1'b0;
         prog_done <= 1'b0;
      end else begin
         rem_q <= rem_after;
         if (stop) begin
            active <= 1'b0;
         end else if (active && rem_after == '0) begin
            active    <= 1'b0;
            data_done <= 1'b1;
            prog_done <= dir_wr;
         end
         if (active && !stop && dir_wr && rem_after != '0) tx_req <= 1'b1;
         else if (host_wr)                               tx_req <= 1'b0;
         if (rx_took)      rx_req <= 1'b1;
         else if (host_rd) rx_req <= 1'b0;
      end
   end
endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned LEN_W = 16,
   localparam int unsigned CW = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_start,
   input  logic             xfer_wr,
   input  logic [LEN_W-1:0] xfer_len,
   input  logic             clk_stop,
   input  logic             pbuf_flush,
   input  logic             hw_en,
   input  logic [2:0]       hw_size,
   input  logic [31:0]      hw_data,
   input  logic             hr_en,
   input  logic [2:0]       hr_size,
   output logic [31:0]      hr_data,
   output logic [7:0]       tx_byte,
   output logic             tx_valid,
   input  logic             tx_ready,
   input  logic [7:0]       rx_byte,
   input  logic             rx_valid,
   output logic             rx_ready,
   output logic             tx_req,
   output logic             rx_req,
   output logic             data_done,
   output logic             prog_done,
   output logic             xfer_active
);
   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("card_data_fifo: DEPTH must be a power of two of at least 4");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("card_data_fifo: LEN_W must be at least 2");
      end
   endgenerate

   logic          dir_wr_q, rem_nz;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_pop, rx_push;

   assign tx_valid = xfer_active && dir_wr_q && rem_nz && (tx_cnt != '0);
   assign rx_ready = xfer_active && !dir_wr_q && rem_nz && (rx_cnt < CW'(DEPTH));
   assign tx_pop   = tx_valid && tx_ready;
   assign rx_push  = rx_valid && rx_ready;

   cdf_txbuf #(.DEPTH(DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_n), .clear(xfer_start), .flip(pbuf_flush),
      .wr_en(hw_en), .wr_size(hw_size), .wr_data(hw_data), .pop(tx_pop),
      .count(tx_cnt), .head(tx_byte)
   );

   cdf_rxring #(.DEPTH(DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_n), .clear(xfer_start), .push(rx_push),
      .push_data(rx_byte), .rd_en(hr_en), .rd_size(hr_size),
      .rd_data(hr_data), .count(rx_cnt)
   );

   cdf_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(xfer_start), .start_wr(xfer_wr),
      .start_len(xfer_len), .stop(clk_stop), .moved(tx_pop || rx_push),
      .rx_took(rx_push), .host_wr(hw_en), .host_rd(hr_en),
      .active(xfer_active), .dir_wr(dir_wr_q), .rem_nz(rem_nz),
      .tx_req(tx_req), .rx_req(rx_req), .data_done(data_done),
      .prog_done(prog_done)
   );
endmodule

// File: rtl/cdf_chk.sv
module cdf_chk (
   input logic clk,
   input logic rst_n,
   input logic xfer_start,
   input logic clk_stop,
   input logic pbuf_flush,
   input logic tx_valid,
   input logic rx_ready,
   input logic rx_valid,
   input logic rx_req,
   input logic data_done,
   input logic prog_done,
   input logic xfer_active,
   input logic dir_wr
);
   p_txv_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (xfer_active && dir_wr));

   p_rxr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> (xfer_active && !dir_wr));

   p_take_sets_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_req) |-> $past(rx_valid && rx_ready));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_done) |-> !xfer_active);

   p_prog_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      prog_done |-> data_done);

   p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pbuf_flush && !xfer_start) |=> !tx_valid);

   p_stop_idles_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop |=> !xfer_active);
endmodule

bind card_data_fifo cdf_chk u_chk (
   .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .clk_stop(clk_stop),
   .pbuf_flush(pbuf_flush), .tx_valid(tx_valid), .rx_ready(rx_ready),
   .rx_valid(rx_valid), .rx_req(rx_req), .data_done(data_done),
   .prog_done(prog_done), .xfer_active(xfer_active), .dir_wr(dir_wr_q)
);

// File: tb/sim_card_data_fifo.sv
`timescale 1ns/1ps
module sim_card_data_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_start = 0, xfer_wr = 0, clk_stop = 0, pbuf_flush = 0;
   logic [15:0] xfer_len = '0;
   logic        hw_en = 0, hr_en = 0;
   logic [2:0]  hw_size = '0, hr_size = '0;
   logic [31:0] hw_data = '0;
   logic [31:0] hr_data;
   logic [7:0]  tx_byte, rx_byte = '0;
   logic        tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
   logic        tx_req, rx_req, data_done, prog_done, xfer_active;

   int n_chk = 0, n_fail = 0;
   logic [7:0] expq[$];

   always #5 clk = ~clk;

   card_data_fifo u0 (.*);

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic start(input bit wr, input int len);
      xfer_start = 1; xfer_wr = wr; xfer_len = 16'(len);
      tick();
      xfer_start = 0;
      expq.delete();
   endtask

   // host write; model queues bytes MS lane first, bounded by model space
   task automatic hwrite(input int sz, input logic [31:0] d, input int room);
      hw_en = 1; hw_size = 3'(sz); hw_data = d;
      for (int i = 0; i < sz && i < room; i++) expq.push_back(8'(d >> (8*(sz-1-i))));
      tick();
      hw_en = 0;
   endtask

   task automatic collect(input int need, input string tag);
      int got = 0;
      tx_ready = 1;
      for (int k = 0; k < need + 8 && got < need; k++) begin
         if (tx_valid) begin
            check(tx_byte == expq[0], tag, 32'(tx_byte), 32'(expq[0]));
            void'(expq.pop_front());
            got++;
         end
         tick();
      end
      tx_ready = 0;
      check(got == need, {tag, " byte count"}, 32'(got), 32'(need));
   endtask

   task automatic t_reset();
      check(!tx_valid && !rx_ready && !xfer_active, "R1 idle", {tx_valid, rx_ready, xfer_active}, 0);
      check(!tx_req && !rx_req && !data_done && !prog_done, "R1 flags",
            {tx_req, rx_req, data_done, prog_done}, 0);
      hr_en = 1; hr_size = 4; #1;
      check(hr_data == 0, "R1 empty read", hr_data, 0);
      tick(); hr_en = 0;
   endtask

   task automatic t_write_basic();
      start(1, 6);
      hwrite(4, 32'h11223344, 32);
      check(tx_req, "R5 tx_req while bytes remain", tx_req, 1);
      hwrite(2, 32'h0000AA55, 28);
      check(tx_req, "R5 host write keeps tx_req", tx_req, 1);
      collect(6, "R2 R4 write order");
      check(!xfer_active && data_done, "R9 write done", {xfer_active, data_done}, 1);
      check(prog_done, "R10 prog_done on write", prog_done, 1);
      check(!tx_valid, "R4 idle after done", tx_valid, 0);
   endtask

   task automatic t_write_sizes();
      start(1, 4);
      hwrite(1, 32'h123456AB, 32);
      check(xfer_active && !data_done, "R13 armed", {xfer_active, data_done}, 2'b10);
      hwrite(3, 32'h99CDEF12, 31);
      collect(4, "R2 sizes 1 and 3");
      check(data_done, "R9 done after sizes", data_done, 1);
   endtask

   task automatic t_write_starve();
      start(1, 3);
      hwrite(2, 32'h0000C0C1, 32);
      collect(2, "R4 partial");
      check(xfer_active && !data_done && !tx_valid, "R4 starved waits",
            {xfer_active, data_done, tx_valid}, 3'b100);
      check(tx_req, "R5 still requesting", tx_req, 1);
      hwrite(1, 32'h000000C2, 32);
      collect(1, "R4 resume");
      check(data_done && prog_done, "R9 R10 after resume", {data_done, prog_done}, 2'b11);
      hwrite(1, 32'h0, 32);
      check(!tx_req, "R5 cleared when none remain", tx_req, 0);
   endtask

   task automatic t_tx_full();
      int room = 32;
      start(1, 40);
      for (int w = 0; w < 9; w++) begin
         hwrite(4, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)}, room);
         room = (room > 4) ? room - 4 : 0;
      end
      check(expq.size() == 32, "R3 model size", expq.size(), 32);
      collect(32, "R3 R4 full buffer");
      check(!tx_valid && xfer_active, "R3 excess dropped", {tx_valid, xfer_active}, 2'b01);
      expq.delete();
      hwrite(4, 32'h20212223, 32);
      hwrite(4, 32'h24252627, 28);
      collect(8, "R4 wrap");
      check(data_done, "R9 long write done", data_done, 1);
   endtask

   task automatic t_flush();
      start(1, 8);
      hwrite(4, 32'h01020304, 32);
      pbuf_flush = 1; expq.delete();
      tick(); pbuf_flush = 0;
      check(!tx_valid && xfer_active, "R11 flushed empty", {tx_valid, xfer_active}, 2'b01);
      pbuf_flush = 1; hw_en = 1; hw_size = 4; hw_data = 32'hEEEEEEEE;
      tick(); pbuf_flush = 0; hw_en = 0;
      check(!tx_valid, "R11 write dropped with flush", tx_valid, 0);
      hwrite(4, 32'hC1C2C3C4, 32);
      hwrite(4, 32'hD1D2D3D4, 28);
      collect(8, "R11 discarded bytes never sent");
      check(data_done, "R11 done", data_done, 1);
   endtask

   task automatic t_read_basic();
      int n = 0;
      start(0, 5);
      check(!prog_done && !data_done, "R13 flags cleared", {prog_done, data_done}, 0);
      rx_valid = 1;
      for (int k = 0; k < 12; k++) begin
         rx_byte = 8'hA0 + 8'(n);
         if (rx_ready) n++;
         tick();
      end
      rx_valid = 0;
      check(n == 5, "R6 five taken", n, 5);
      check(data_done && !prog_done && !xfer_active, "R9 R10 read done",
            {data_done, prog_done, xfer_active}, 3'b100);
      check(rx_req, "R7 rx_req set", rx_req, 1);
      hr_en = 1; hr_size = 4; #1;
      check(hr_data == 32'hA0A1A2A3, "R8 read 4", hr_data, 32'hA0A1A2A3);
      tick();
      #1;
      check(hr_data == 32'hA4000000, "R8 short read lanes", hr_data, 32'hA4000000);
      tick(); hr_en = 0;
      check(!rx_req, "R7 rx_req cleared", rx_req, 0);
      hr_en = 1; hr_size = 2; #1;
      check(hr_data == 0, "R8 empty ring", hr_data, 0);
      tick(); hr_en = 0;
   endtask

   task automatic t_read_full();
      int n = 0, rc = 0, bad = 0;
      start(0, 40);
      rx_valid = 1;
      for (int k = 0; k < 40; k++) begin
         rx_byte = 8'(n);
         if (rx_ready) n++;
         tick();
      end
      check(n == 32 && !rx_ready && xfer_active, "R6 ring full stalls",
            {8'(n), 7'd0, rx_ready, 7'd0, xfer_active}, {8'd32, 16'h0001});
      for (int k = 0; k < 120 && rc < 40; k++) begin
         rx_byte = 8'(n);
         if (rx_ready != (n < 40 && n - rc < 32)) bad++;
         if (n - rc >= 4) begin
            hr_en = 1; hr_size = 4; #1;
            check(hr_data == {8'(rc), 8'(rc+1), 8'(rc+2), 8'(rc+3)}, "R6 R8 wrap order",
                  hr_data, {8'(rc), 8'(rc+1), 8'(rc+2), 8'(rc+3)});
            rc += 4;
         end
         if (rx_ready) n++;
         tick();
         hr_en = 0;
      end
      rx_valid = 0;
      check(bad == 0, "R6 rx_ready tracks room", bad, 0);
      check(rc == 40 && data_done, "R9 long read done", {8'(rc), 7'd0, data_done}, {8'd40, 8'd1});
   endtask

   task automatic t_stop();
      start(0, 10);
      clk_stop = 1; tick(); clk_stop = 0;
      rx_valid = 1; #1;
      check(!xfer_active && !rx_ready, "R12 stopped", {xfer_active, rx_ready}, 0);
      tick(); rx_valid = 0;
      check(!data_done && !rx_req, "R12 no done", {data_done, rx_req}, 0);
      xfer_start = 1; xfer_wr = 1; xfer_len = 4; clk_stop = 1;
      tick(); xfer_start = 0; clk_stop = 0;
      check(!xfer_active, "R12 stop beats start", xfer_active, 0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_write_basic();
      t_write_sizes();
      t_write_starve();
      t_tx_full();
      t_flush();
      t_read_basic();
      t_read_full();
      t_stop();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule